// File: doc/BRIEF.md
# Armed Start-Pattern Receive Deframer

This block sits behind a demodulator and clock-recovery stage. It watches a serial stream of received bits, each qualified by a one-cycle valid strobe, for a programmable start pattern. Detection is a one-shot. A host write arms it, and it searches only while the mode input selects receive. When the pattern is found, the block disarms itself and starts a capture.

During a capture, every following bit is packed into bytes, most significant bit first. Each byte is written into a small receive FIFO, and a one-cycle interrupt pulse marks every stored byte. The preamble and the start pattern never reach the FIFO. A capture ends when the mode leaves receive. The host drains bytes through a show-ahead read port and finds the message length itself, from a length byte or an end marker.

Top module: `rx_sync_deframer`

## Requirements
- R1: Before the first write to `arm_i`, no received bit can start a capture: the FIFO stays empty and `irq0_o` stays low.
- R2: Detection and capture happen only while `mode_i` equals 3'b011 (receive). An arm made in any other mode (standby is 3'b001) keeps `armed_o` high and stores nothing.
- R3: `pat_len_i` selects the start pattern length: code 0, 1, 2 and 3 give 8, 16, 24 and 32 bits. The pattern is `pat_i[L-1:0]`, and `pat_i[L-1]` is the first bit on air. Bits of `pat_i` above L are ignored, and a mismatch in any one bit of the L bits prevents detection.
- R4: The first stored byte consists of the 8 bits that follow the last start-pattern bit. No preamble or pattern bit is stored.
- R5: Bytes are assembled MSB first: the first data bit received lands in bit 7.
- R6: Each stored byte gives `irq0_o` high for exactly one clock. The pulse begins at the second rising edge after the strobe of the byte's eighth bit, and the byte is readable from that same edge.
- R7: A match clears `armed_o` and raises `capturing_o`. Without a new arm write, no further pattern search takes place.
- R8: When `mode_i` leaves receive, `capturing_o` falls at the next edge and any partial byte is discarded.
- R9: A byte that completes while the FIFO is full is dropped, gives no interrupt, and sets `ovf_o`. `ovf_o` stays set until reset.
- R10: While `rx_empty_o` is low, `rx_data_o` shows the oldest stored byte, and a cycle with `rd_en_i` high removes it. Bytes come out in arrival order. After reset the FIFO is empty, and `armed_o`, `capturing_o`, `irq0_o` and `ovf_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 3 | Operating mode; 3'b011 is receive |
| arm_i | input | 1 | One-cycle host write of 1 to the arm bit |
| pat_i | input | 32 | Start pattern value |
| pat_len_i | input | 2 | Start pattern length code |
| bit_i | input | 1 | Received data bit |
| bit_vld_i | input | 1 | Strobe marking a new received bit |
| rd_en_i | input | 1 | Pop the oldest FIFO byte |
| rx_data_o | output | 8 | Oldest FIFO byte (show-ahead) |
| rx_empty_o | output | 1 | FIFO holds no byte |
| irq0_o | output | 1 | One-cycle pulse per stored byte |
| ovf_o | output | 1 | Sticky overflow flag |
| armed_o | output | 1 | Pattern search is armed |
| capturing_o | output | 1 | Capture in progress |

## Verification
A corrupted pattern history or fill count shows up at the ports in one of two ways. Either a capture starts too early, and `rx_data_o` then yields bytes made of pattern or preamble bits, or no match occurs and `rx_empty_o` never falls. Both are visible within a few cycles of the frame's end. A wrong bit counter or shift order in the packer gives a wrongly aligned or bit-reversed first byte when the FIFO is drained. A stuck capture or arm flag is exposed at once by `capturing_o` and `armed_o`. A FIFO count error shows as a missing or extra interrupt, a missing or extra byte on readout, or `ovf_o` rising in the wrong place.

// File: rtl/rxdf_pkg.sv
package rxdf_pkg;

    localparam int BYTE_W     = 8;
    localparam int LEN_CODE_W = 2;

    typedef enum logic [2:0] {
        MODE_SLEEP   = 3'b000,
        MODE_STANDBY = 3'b001,
        MODE_SYNTH   = 3'b010,
        MODE_RX      = 3'b011,
        MODE_TX      = 3'b100
    } rx_mode_e;

    typedef struct packed {
        logic              vld;
        logic [BYTE_W-1:0] data;
    } rx_byte_t;

    // Number of pattern bits selected by a length code.
    function automatic int unsigned pat_bits(input logic [LEN_CODE_W-1:0] code);
        return (int'(code) + 1) * 8;
    endfunction

endpackage

// File: rtl/rxdf_sync_detect.sv
module rxdf_sync_detect
    import rxdf_pkg::*;
#(
    parameter int PAT_W = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  clear_i,
    input  logic                  shift_i,
    input  logic                  bit_i,
    input  logic [PAT_W-1:0]      pat_i,
    input  logic [LEN_CODE_W-1:0] len_i,
    output logic                  match_o
);
    localparam int CW = $clog2(PAT_W + 1);

    logic [PAT_W-2:0] hist_q;
    logic [CW-1:0]    fill_q;
    logic [PAT_W-1:0] hist_nx;
    logic [CW-1:0]    fill_nx;
    logic [CW-1:0]    need;
    logic [PAT_W-1:0] mask;

    always_comb begin
        hist_nx = {hist_q, bit_i};
        fill_nx = (fill_q == CW'(PAT_W)) ? fill_q : fill_q + 1'b1;
        need    = CW'(pat_bits(len_i));
        mask    = ~({PAT_W{1'b1}} << need);
        match_o = shift_i && (fill_nx >= need) && (((hist_nx ^ pat_i) & mask) == '0);
    end

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            hist_q <= '0;
            fill_q <= '0;
        end else if (shift_i) begin
            hist_q <= hist_nx[PAT_W-2:0];
            fill_q <= fill_nx;
        end
    end

endmodule

// File: rtl/rxdf_byte_packer.sv
module rxdf_byte_packer
    import rxdf_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     flush_i,
    input  logic     bit_vld_i,
    input  logic     bit_i,
    output rx_byte_t out_o
);
    localparam int BCW = $clog2(BYTE_W);

    logic [BYTE_W-2:0] shreg_q;
    logic [BCW-1:0]    cnt_q;

    always_ff @(posedge clk) begin
        if (rst || flush_i) begin
            shreg_q  <= '0;
            cnt_q    <= '0;
            out_o    <= '0;
        end else begin
            out_o.vld <= 1'b0;
            if (bit_vld_i) begin
                if (cnt_q == BCW'(BYTE_W - 1)) begin
                    out_o.data <= {shreg_q, bit_i};
                    out_o.vld  <= 1'b1;
                    cnt_q      <= '0;
                end else begin
                    shreg_q <= {shreg_q[BYTE_W-3:0], bit_i};
                    cnt_q   <= cnt_q + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/rxdf_fifo.sv
module rxdf_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    input  logic         rd_i,
    output logic [W-1:0] rdata_o,
    output logic         empty_o,
    output logic         full_o
);
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNTW = $clog2(DEPTH + 1);

    logic [W-1:0]    mem [DEPTH];
    logic [AW-1:0]   wp_q, rp_q;
    logic [CNTW-1:0] cnt_q;
    logic            do_wr, do_rd;

    assign empty_o = (cnt_q == '0);
    assign full_o  = (cnt_q == CNTW'(DEPTH));
    assign do_wr   = wr_i && !full_o;
    assign do_rd   = rd_i && !empty_o;
    assign rdata_o = mem[rp_q];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_wr) mem[wp_q] <= wdata_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_wr) wp_q <= bump(wp_q);
            if (do_rd) rp_q <= bump(rp_q);
            case ({do_wr, do_rd})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

endmodule

// File: rtl/rx_sync_deframer.sv
module rx_sync_deframer
    import rxdf_pkg::*;
#(
    parameter int PAT_W = 32,
    parameter int DEPTH = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [2:0]            mode_i,
    input  logic                  arm_i,
    input  logic [PAT_W-1:0]      pat_i,
    input  logic [LEN_CODE_W-1:0] pat_len_i,
    input  logic                  bit_i,
    input  logic                  bit_vld_i,
    input  logic                  rd_en_i,
    output logic [BYTE_W-1:0]     rx_data_o,
    output logic                  rx_empty_o,
    output logic                  irq0_o,
    output logic                  ovf_o,
    output logic                  armed_o,
    output logic                  capturing_o
);
    logic     in_rx;
    logic     armed_q, cap_q, irq_q, ovf_q;
    logic     search, match;
    logic     fifo_full, push;
    rx_byte_t pk_byte;

    assign in_rx  = (mode_i == MODE_RX);
    assign search = armed_q && !cap_q && in_rx && bit_vld_i;

    rxdf_sync_detect #(.PAT_W(PAT_W)) u_detect (
        .clk     (clk),
        .rst     (rst),
        .clear_i (arm_i),
        .shift_i (search),
        .bit_i   (bit_i),
        .pat_i   (pat_i),
        .len_i   (pat_len_i),
        .match_o (match)
    );

    rxdf_byte_packer u_packer (
        .clk       (clk),
        .rst       (rst),
        .flush_i   (!cap_q),
        .bit_vld_i (cap_q && in_rx && bit_vld_i),
        .bit_i     (bit_i),
        .out_o     (pk_byte)
    );

    assign push = pk_byte.vld && !fifo_full;

    rxdf_fifo #(.DEPTH(DEPTH), .W(BYTE_W)) u_fifo (
        .clk     (clk),
        .rst     (rst),
        .wr_i    (push),
        .wdata_i (pk_byte.data),
        .rd_i    (rd_en_i),
        .rdata_o (rx_data_o),
        .empty_o (rx_empty_o),
        .full_o  (fifo_full)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
            cap_q   <= 1'b0;
            irq_q   <= 1'b0;
            ovf_q   <= 1'b0;
        end else begin
            if (match)      armed_q <= 1'b0;
            else if (arm_i) armed_q <= 1'b1;

            if (!in_rx)     cap_q <= 1'b0;
            else if (match) cap_q <= 1'b1;

            irq_q <= push;
            ovf_q <= ovf_q | (pk_byte.vld && fifo_full);
        end
    end

    assign irq0_o      = irq_q;
    assign ovf_o       = ovf_q;
    assign armed_o     = armed_q;
    assign capturing_o = cap_q;

endmodule

// File: rtl/rxdf_checker.sv
module rxdf_checker
    import rxdf_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic [2:0] mode_i,
    input logic       irq0_o,
    input logic       rx_empty_o,
    input logic       ovf_o,
    input logic       armed_o,
    input logic       capturing_o
);
    AST_IRQ_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        irq0_o |=> !irq0_o);                                    // R6
    AST_IRQ_BYTE_PRESENT: assert property (@(posedge clk) disable iff (rst)
        irq0_o |-> !rx_empty_o);                                // R6
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        ovf_o |=> ovf_o);                                       // R9
    AST_MATCH_DISARMS: assert property (@(posedge clk) disable iff (rst)
        $rose(capturing_o) |-> !armed_o);                       // R7
    AST_NO_START_UNARMED: assert property (@(posedge clk) disable iff (rst)
        !armed_o |=> !$rose(capturing_o));                      // R1
    AST_CAPTURE_ONLY_RX: assert property (@(posedge clk) disable iff (rst)
        (mode_i != MODE_RX) |=> !capturing_o);                  // R8
endmodule

bind rx_sync_deframer rxdf_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .mode_i      (mode_i),
    .irq0_o      (irq0_o),
    .rx_empty_o  (rx_empty_o),
    .ovf_o       (ovf_o),
    .armed_o     (armed_o),
    .capturing_o (capturing_o)
);

// File: tb/tb_rx_sync_deframer.sv
module tb_rx_sync_deframer;
    localparam int DEPTH = 4;
    localparam logic [2:0] M_RX = 3'b011;
    localparam logic [2:0] M_SB = 3'b001;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  mode_i = M_SB;
    logic        arm_i = 1'b0;
    logic [31:0] pat_i = '0;
    logic [1:0]  pat_len_i = '0;
    logic        bit_i = 1'b0;
    logic        bit_vld_i = 1'b0;
    logic        rd_en_i = 1'b0;
    logic [7:0]  rx_data_o;
    logic        rx_empty_o, irq0_o, ovf_o, armed_o, capturing_o;

    int n_chk = 0, n_fail = 0, irq_cnt = 0;
    bit irq_prev = 1'b0;
    bit exp_ovf = 1'b0;
    logic [7:0] exp_q[$];

    always #5 clk = ~clk;

    rx_sync_deframer #(.PAT_W(32), .DEPTH(DEPTH)) dut (.*);

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: counts interrupts and checks their width
    always @(negedge clk) begin
        if (!rst) begin
            if (irq0_o && irq_prev) chk(1'b0, "R6 pulse width", 2, 1);
            if (irq0_o) irq_cnt++;
            irq_prev = irq0_o;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bits(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            @(negedge clk);
            bit_i = v[i];
            bit_vld_i = 1'b1;
            @(negedge clk);
            bit_vld_i = 1'b0;
        end
    endtask

    // Driver: sends a data byte and records what should be stored
    task automatic send_byte(input logic [7:0] b, input bit stored);
        if (stored) begin
            if (exp_q.size() < DEPTH) exp_q.push_back(b);
            else exp_ovf = 1'b1;
        end
        send_bits({24'h0, b}, 8);
    endtask

    task automatic arm();
        @(negedge clk);
        arm_i = 1'b1;
        @(negedge clk);
        arm_i = 1'b0;
    endtask

    // Scoreboard drain: pop FIFO and compare against the expected queue
    task automatic drain(input string req);
        logic [7:0] e;
        int guard = 0;
        while (!rx_empty_o && guard < 64) begin
            guard++;
            if (exp_q.size() == 0) begin
                chk(1'b0, {req, " extra byte"}, rx_data_o, 0);
            end else begin
                e = exp_q.pop_front();
                chk(rx_data_o == e, req, rx_data_o, e);
            end
            rd_en_i = 1'b1;
            @(negedge clk);
            rd_en_i = 1'b0;
        end
        chk(exp_q.size() == 0, {req, " missing bytes"}, exp_q.size(), 0);
        exp_q.delete();
    endtask

    initial begin
        fork
            begin
                repeat (150000) @(posedge clk);
                chk(1'b0, "watchdog", 1, 0);
                $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
                $finish;
            end
        join_none

        idle(3);
        rst = 1'b0;
        idle(1);
        // R10 reset state
        chk(rx_empty_o == 1'b1, "R10 reset empty", rx_empty_o, 1);
        chk({armed_o, capturing_o, irq0_o, ovf_o} == 4'b0, "R10 reset flags",
            {armed_o, capturing_o, irq0_o, ovf_o}, 0);

        // R1: receive mode, never armed
        pat_i = 32'h0000_D391; pat_len_i = 2'd1; mode_i = M_RX;
        send_bits(32'hAAAA, 16); send_bits(32'hD391, 16); send_byte(8'h5C, 1'b0);
        idle(4);
        chk(rx_empty_o == 1'b1, "R1 unarmed store", rx_empty_o, 1);
        chk(irq_cnt == 0, "R1 unarmed irq", irq_cnt, 0);

        // R2: armed in standby
        mode_i = M_SB; arm();
        send_bits(32'hAAAA, 16); send_bits(32'hD391, 16); send_byte(8'h5C, 1'b0);
        idle(4);
        chk(rx_empty_o == 1'b1, "R2 standby store", rx_empty_o, 1);
        chk(armed_o == 1'b1, "R2 arm kept", armed_o, 1);

        // R4 R5 R6 R7 R10: 16-bit pattern frame
        mode_i = M_RX;
        send_bits(32'hAAAA, 16); send_bits(32'hD391, 16);
        idle(1);
        chk(armed_o == 1'b0 && capturing_o == 1'b1, "R7 disarm on match",
            {armed_o, capturing_o}, 2'b01);
        chk(rx_empty_o == 1'b1, "R4 pattern not stored", rx_empty_o, 1);
        send_byte(8'h5C, 1'b1); send_byte(8'h3E, 1'b1);
        idle(4);
        chk(irq_cnt == 2, "R6 irq per byte", irq_cnt, 2);
        drain("R5 R10 frame bytes");

        // R6 timing: pulse at second edge after last strobe
        irq_cnt = 0;
        send_bits(32'h1, 7);
        @(negedge clk); bit_i = 1'b1; bit_vld_i = 1'b1;
        @(negedge clk); bit_vld_i = 1'b0;
        chk(irq0_o == 1'b0 && rx_empty_o == 1'b1, "R6 not yet", irq0_o, 0);
        @(negedge clk);
        chk(irq0_o == 1'b1 && rx_empty_o == 1'b0, "R6 pulse edge", irq0_o, 1);
        exp_q.push_back(8'h03);
        idle(2);
        drain("R6 timed byte");

        // R8: partial byte discarded, no capture after leaving receive
        send_bits(32'h15, 5);
        mode_i = M_SB;
        idle(1);
        chk(capturing_o == 1'b0, "R8 capture ends", capturing_o, 0);
        mode_i = M_RX;
        send_bits(32'hD391, 16); send_byte(8'h77, 1'b0);
        idle(4);
        chk(rx_empty_o == 1'b1, "R8 R7 no rearm", rx_empty_o, 1);
        chk(capturing_o == 1'b0, "R7 no second search", capturing_o, 0);

        // R3: 8-bit pattern with garbage above
        mode_i = M_SB; pat_i = 32'hFFFF_FF2D; pat_len_i = 2'd0; arm(); mode_i = M_RX;
        send_bits(32'hAA, 8); send_bits(32'h2D, 8); send_byte(8'h81, 1'b1);
        idle(4);
        drain("R3 8-bit");

        // R3: 24-bit pattern
        mode_i = M_SB; pat_i = 32'h12C3_A5F0; pat_len_i = 2'd2; arm(); mode_i = M_RX;
        send_bits(32'hAAAA, 16); send_bits(32'hC3A5F0, 24); send_byte(8'h07, 1'b1);
        idle(4);
        drain("R3 24-bit");

        // R3: 32-bit pattern with a one-bit near miss first
        mode_i = M_SB; pat_i = 32'h9E2B_7714; pat_len_i = 2'd3; arm(); mode_i = M_RX;
        send_bits(32'hAA, 8); send_bits(32'h9E2B_7715, 32);
        idle(1);
        chk(capturing_o == 1'b0, "R3 near miss", capturing_o, 0);
        send_bits(32'h9E2B_7714, 32); send_byte(8'hE1, 1'b1);
        idle(4);
        drain("R3 32-bit");

        // R9: overflow
        chk(ovf_o == 1'b0, "R9 no overflow yet", ovf_o, 0);
        irq_cnt = 0;
        mode_i = M_SB; pat_i = 32'h0000_D391; pat_len_i = 2'd1; arm(); mode_i = M_RX;
        send_bits(32'hAAAA, 16); send_bits(32'hD391, 16);
        for (int k = 1; k <= 6; k++) send_byte(8'(k), 1'b1);
        idle(4);
        chk(ovf_o == exp_ovf, "R9 overflow flag", ovf_o, exp_ovf);
        chk(irq_cnt == DEPTH, "R9 irq only stored", irq_cnt, DEPTH);
        drain("R9 kept bytes");
        idle(2);
        chk(ovf_o == 1'b1, "R9 sticky", ovf_o, 1);
        mode_i = M_SB;

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule